// File: doc/BRIEF.md
# Two-Group DAC Command Front End

This block is the digital command path that sits in front of sixteen output DACs. The DACs are split into two groups of eight. Both groups share one serial clock line and one data line, and each group has its own active-low frame select. A host sends 32-bit command frames, most significant bit first. Each frame carries an operation, a channel address and a 12-bit data field.

On the last bit of a frame, the selected groups carry out the operation. An operation can load an input register, move input registers into DAC registers, change the per-channel power-down mask, set the software load-override mask, turn the group reference request on or off, or program the group's clear code. Two hardware pins, a load strobe and a clear, decide when the DAC registers take new values.

All serial and pin inputs are sampled on the system clock, and their edges are detected there. The serial clock must therefore be slower than the system clock. Each serial clock level must last at least two system clocks.

Top module: `dac_serial_front`

## Requirements
- R1: While at least one frame select is low, a bit is taken from `sdin_i` on each falling edge of `sclk_i`, most significant bit first. The frame takes effect on the 32nd falling edge. Frame layout: bits 27:24 are the operation, bits 23:20 the address, and bits 19:8 the data. The remaining bits are ignored, except bit 0 in the reference operation.
- R2: If a frame select rises before the 32nd falling edge, the partial frame is discarded and no state changes.
- R3: A frame acts only on the groups whose select is low when it completes. Group 0 (`sync_n_i[0]`) holds channels 0 to 7 and group 1 (`sync_n_i[1]`) holds channels 8 to 15. Within a group, addresses 0 to 7 pick one channel and address 15 picks all eight.
- R4: Operation 0 writes the data field into the addressed input registers. The DAC register is unchanged while `ldac_n_i` is high and the channel's override bit is clear.
- R5: While `ldac_n_i` is low, every DAC register takes the value of its input register.
- R6: Operation 5 loads an override mask from data bits 7:0 (bit k is channel k of the group). A channel with its override bit set has its DAC register follow its input register whatever the level of `ldac_n_i`.
- R7: Operation 1 copies the addressed input registers into their DAC registers. Operation 2 writes the data field into both the addressed input registers and their DAC registers.
- R8: Operation 3 sets the group's power-down mask from data bits 7:0 (1 means powered down). The new mask appears on `pwr_dn_o`, and DAC register contents are kept.
- R9: Operation 6 sets the group's reference request from frame bit 0 and ignores the address. `ref_en_o[g]` is high only when the request is set and at least one channel of group g is powered up.
- R10: Operation 4 stores the data field as the group's clear code. While `clr_n_i` is low, every DAC register holds its group's clear code. This takes priority over loading, and input registers are not changed.
- R11: After reset, all input and DAC registers are zero, the override and power-down masks are clear, and both reference requests are off.
- R12: Falling edges after the 32nd one, with the select still low, are ignored until the select rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles high |
| sdin_i | input | 1 | Serial data |
| sync_n_i | input | 2 | Active-low frame select, one per group |
| ldac_n_i | input | 1 | Active-low load strobe |
| clr_n_i | input | 1 | Active-low clear |
| dac_code_o | output | 192 | DAC register codes; channel c is bits 12c+11 down to 12c |
| pwr_dn_o | output | 16 | Power-down state per channel |
| ref_en_o | output | 2 | Reference enable per group |

## Verification
The bench targets the frame-boundary cases. A frame cut short after 20 bits must leave the channel untouched; a design that kept the shifted bits would write garbage. A second 32 bits sent under the same select must not run as a second command; a design that wraps its bit counter would overwrite the first result. It also checks group isolation with an all-channels address, and that overridden and non-overridden channels behave differently under a write while the strobe is high. It confirms that the clear code beats the load path while input registers survive, and that the reference enable drops only when the whole group is powered down.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    localparam int FRAME_BITS = 32;
    localparam int OP_LSB     = 24;
    localparam int ADDR_LSB   = 20;
    localparam int FIELD_TOP  = 20;

    typedef enum logic [3:0] {
        OP_LOAD_IN   = 4'd0,
        OP_UPDATE    = 4'd1,
        OP_LOAD_UPD  = 4'd2,
        OP_POWER     = 4'd3,
        OP_CLR_CODE  = 4'd4,
        OP_OVERRIDE  = 4'd5,
        OP_REFERENCE = 4'd6
    } op_e;
endpackage

// File: rtl/dsf_shift.sv
module dsf_shift #(
    parameter int FRAME = 32,
    parameter int NGRP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdin_i,
    input  logic [NGRP-1:0]  syncn_i,
    output logic             exec_o,
    output logic [FRAME-1:0] word_o,
    output logic [NGRP-1:0]  grp_o
);
    localparam int CW = $clog2(FRAME + 1);

    typedef struct packed {
        logic             sclk;
        logic             sclk_p;
        logic             sdin;
        logic [NGRP-1:0]  syncn;
        logic [NGRP-1:0]  syncn_p;
        logic [CW-1:0]    cnt;
        logic [FRAME-1:0] shreg;
    } st_t;

    st_t st_q, st_d;
    logic fall, rise, active;

    always_comb begin
        st_d         = st_q;
        st_d.sclk    = sclk_i;
        st_d.sclk_p  = st_q.sclk;
        st_d.sdin    = sdin_i;
        st_d.syncn   = syncn_i;
        st_d.syncn_p = st_q.syncn;
        fall   = st_q.sclk_p & ~st_q.sclk;
        rise   = |(st_q.syncn & ~st_q.syncn_p);
        active = ~&st_q.syncn;
        word_o = {st_q.shreg[FRAME-2:0], st_q.sdin};
        exec_o = fall & active & ~rise & (st_q.cnt == CW'(FRAME - 1));
        grp_o  = ~st_q.syncn;
        if (!active || rise) begin
            st_d.cnt = '0;
        end else if (fall && st_q.cnt != CW'(FRAME)) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.shreg = word_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.sclk    <= 1'b1;
            st_q.sclk_p  <= 1'b1;
            st_q.syncn   <= '1;
            st_q.syncn_p <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R12
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(FRAME)) |-> !exec_o);

    // R1
    exec_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> (st_q.cnt == CW'(FRAME)) || (st_q.cnt == '0));
endmodule

// File: rtl/dsf_group.sv
module dsf_group
    import dsf_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DW    = 12,
    parameter int FRAME = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [FRAME-1:0]  word_i,
    input  logic              ldac_n_i,
    input  logic              clr_n_i,
    output logic [NCH*DW-1:0] dac_o,
    output logic [NCH-1:0]    pwr_dn_o,
    output logic              ref_en_o
);
    localparam int DATA_LSB = FIELD_TOP - DW;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] inr;
        logic [NCH-1:0][DW-1:0] dac;
        logic [NCH-1:0]         pd;
        logic [NCH-1:0]         ovr;
        logic [DW-1:0]          clrc;
        logic                   ref_req;
    } grp_t;

    grp_t g_q, g_d;
    op_e             op;
    logic [3:0]      addr;
    logic [DW-1:0]   data;
    logic [NCH-1:0]  mask;
    logic [NCH-1:0]  sel;

    always_comb begin
        g_d  = g_q;
        op   = op_e'(word_i[OP_LSB +: 4]);
        addr = word_i[ADDR_LSB +: 4];
        data = word_i[DATA_LSB +: DW];
        mask = word_i[DATA_LSB +: NCH];
        for (int i = 0; i < NCH; i++) begin
            sel[i] = exec_i && (addr == 4'hF || addr == 4'(i));
            if (sel[i] && (op == OP_LOAD_IN || op == OP_LOAD_UPD))
                g_d.inr[i] = data;
            if (!clr_n_i)
                g_d.dac[i] = g_q.clrc;
            else if (!ldac_n_i || g_q.ovr[i])
                g_d.dac[i] = g_q.inr[i];
            else if (sel[i] && op == OP_UPDATE)
                g_d.dac[i] = g_q.inr[i];
            else if (sel[i] && op == OP_LOAD_UPD)
                g_d.dac[i] = data;
        end
        if (exec_i) begin
            case (op)
                OP_POWER:     g_d.pd      = mask;
                OP_CLR_CODE:  g_d.clrc    = data;
                OP_OVERRIDE:  g_d.ovr     = mask;
                OP_REFERENCE: g_d.ref_req = word_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign dac_o    = g_q.dac;
    assign pwr_dn_o = g_q.pd;
    assign ref_en_o = g_q.ref_req & ~&g_q.pd;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            // R10
            clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_n_i |=> g_q.dac[c] == $past(g_q.clrc));
            // R6
            ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_n_i && g_q.ovr[c]) |=> g_q.dac[c] == $past(g_q.inr[c]));
            // R4
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_n_i && ldac_n_i && !g_q.ovr[c] && !exec_i) |=> $stable(g_q.dac[c]));
        end
    endgenerate

    // R8
    pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_POWER && clr_n_i && ldac_n_i && g_q.ovr == '0)
        |=> $stable(g_q.dac));
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dsf_pkg::*;
#(
    parameter int NGRP = 2,
    parameter int NCH  = 8,
    parameter int DW   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk_i,
    input  logic                   sdin_i,
    input  logic [NGRP-1:0]        sync_n_i,
    input  logic                   ldac_n_i,
    input  logic                   clr_n_i,
    output logic [NGRP*NCH*DW-1:0] dac_code_o,
    output logic [NGRP*NCH-1:0]    pwr_dn_o,
    output logic [NGRP-1:0]        ref_en_o
);
    localparam int GW = NCH * DW;

    typedef struct packed {
        logic ldac_n;
        logic clr_n;
    } pin_t;

    pin_t pin_q, pin_d;
    logic                  exec;
    logic [FRAME_BITS-1:0] word;
    logic [NGRP-1:0]       grp;

    always_comb begin
        pin_d.ldac_n = ldac_n_i;
        pin_d.clr_n  = clr_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '1;
        else        pin_q <= pin_d;
    end

    dsf_shift #(.FRAME(FRAME_BITS), .NGRP(NGRP)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .sdin_i  (sdin_i),
        .syncn_i (sync_n_i),
        .exec_o  (exec),
        .word_o  (word),
        .grp_o   (grp)
    );

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            dsf_group #(.NCH(NCH), .DW(DW), .FRAME(FRAME_BITS)) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .exec_i   (exec & grp[g]),
                .word_i   (word),
                .ldac_n_i (pin_q.ldac_n),
                .clr_n_i  (pin_q.clr_n),
                .dac_o    (dac_code_o[g*GW +: GW]),
                .pwr_dn_o (pwr_dn_o[g*NCH +: NCH]),
                .ref_en_o (ref_en_o[g])
            );
        end
    endgenerate
endmodule

// File: tb/dac_serial_front_tb_top.sv
module dac_serial_front_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [1:0]   sync_n = 2'b11;
    logic [191:0] dac_code;
    logic [15:0]  pwr_dn;
    logic [1:0]   ref_en;

    int tests = 0, fails = 0;
    bit done = 0;

    typedef struct {
        int    kind;
        int    idx;
        int    exp;
        string req;
    } item_t;
    item_t sb[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    dac_serial_front dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin),
        .sync_n_i(sync_n), .ldac_n_i(ldac_n), .clr_n_i(clr_n),
        .dac_code_o(dac_code), .pwr_dn_o(pwr_dn), .ref_en_o(ref_en)
    );

    function automatic logic [31:0] fw(input int op, input int addr, input int data);
        return {4'h0, 4'(op), 4'(addr), 12'(data), 8'h00};
    endfunction

    task automatic expect_item(input int kind, input int idx, input int exp, input string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic verify();
        @(negedge clk);
        ->sample_ev;
        #1;
    endtask

    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                int got;
                it = sb.pop_front();
                case (it.kind)
                    0:       got = int'(dac_code[it.idx*12 +: 12]);
                    1:       got = int'(pwr_dn);
                    default: got = int'(ref_en);
                endcase
                tests++;
                if (got != it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d idx=%0d actual=0x%0h expected=0x%0h",
                             it.req, it.kind, it.idx, got, it.exp);
                end
            end
        end
    end

    task automatic send(input logic [1:0] g, input logic [63:0] s, input int n);
        @(negedge clk);
        sync_n = ~g;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdin = s[63-i];
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sync_n = 2'b11;
        repeat (5) @(negedge clk);
    endtask

    task automatic pins(input logic l, input logic c);
        @(negedge clk);
        ldac_n = l;
        clr_n  = c;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        expect_item(0, 0, 0, "R11");
        expect_item(0, 15, 0, "R11");
        expect_item(1, 0, 0, "R11");
        expect_item(2, 0, 0, "R11");
        verify();

        // R4 input write leaves DAC alone with strobe high
        send(2'b01, {fw(0, 2, 'h123), 32'h0}, 32);
        expect_item(0, 2, 0, "R4");
        verify();
        // R7 update copies input to DAC; R1 frame decoded
        send(2'b01, {fw(1, 2, 0), 32'h0}, 32);
        expect_item(0, 2, 'h123, "R7");
        verify();
        // R3 all-channel write on group 1 only
        send(2'b10, {fw(2, 15, 'hABC), 32'h0}, 32);
        expect_item(0, 8, 'hABC, "R3");
        expect_item(0, 15, 'hABC, "R3");
        expect_item(0, 0, 0, "R3");
        verify();
        // R2 truncated frame discarded
        send(2'b01, {fw(2, 1, 'h555), 32'h0}, 20);
        expect_item(0, 1, 0, "R2");
        verify();
        // R12 second 32 bits under same select ignored
        send(2'b01, {fw(2, 3, 'h0F0), fw(2, 3, 'h777)}, 64);
        expect_item(0, 3, 'h0F0, "R12");
        verify();
        // R5 strobe low makes DAC follow input
        pins(1'b0, 1'b1);
        send(2'b01, {fw(0, 4, 'h321), 32'h0}, 32);
        expect_item(0, 4, 'h321, "R5");
        verify();
        pins(1'b1, 1'b1);
        // R6 override on channel 5 only
        send(2'b01, {fw(5, 0, 'h020), 32'h0}, 32);
        send(2'b01, {fw(0, 5, 'h444), 32'h0}, 32);
        send(2'b01, {fw(0, 6, 'h666), 32'h0}, 32);
        expect_item(0, 5, 'h444, "R6");
        expect_item(0, 6, 0, "R6");
        verify();
        // R9 reference on for both groups
        send(2'b11, {fw(6, 9, 0) | 32'h1, 32'h0}, 32);
        expect_item(2, 0, 3, "R9");
        verify();
        // R8 power down all of group 0, contents kept
        send(2'b01, {fw(3, 0, 'h0FF), 32'h0}, 32);
        expect_item(1, 0, 'h00FF, "R8");
        expect_item(0, 2, 'h123, "R8");
        expect_item(2, 0, 2, "R9");
        verify();
        send(2'b01, {fw(3, 0, 'h001), 32'h0}, 32);
        expect_item(1, 0, 'h0001, "R8");
        expect_item(2, 0, 3, "R9");
        verify();
        // R10 clear code beats load path; inputs kept
        send(2'b11, {fw(4, 0, 'h800), 32'h0}, 32);
        pins(1'b0, 1'b0);
        expect_item(0, 0, 'h800, "R10");
        expect_item(0, 15, 'h800, "R10");
        expect_item(0, 5, 'h800, "R10");
        verify();
        pins(1'b0, 1'b1);
        expect_item(0, 4, 'h321, "R10");
        expect_item(0, 9, 'hABC, "R10");
        verify();
        pins(1'b1, 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule